// File: doc/BRIEF.md
# DMA Controller Host Register Interface

This block is the 8-bit, port-mapped programming front end of a four-channel DMA controller. A host reads and writes sixteen byte-wide ports. The lower eight ports reach each channel's 16-bit start offset and 16-bit block count one byte at a time. The upper eight ports hold the command byte, the per-channel mode, the channel masks and the software requests. They also include several write-only strobe ports: one returns the byte pointer to the low byte, one resets the whole controller and one unmasks every channel. A read of the command port returns a status byte.

One byte-pointer flip-flop is shared by every 16-bit port. It selects the low or the high byte and toggles after each byte access to any of those ports, whether the access is a read or a write. A write to a 16-bit port loads the programmed base value. A read of the same port returns the live current value reported by the channel engines. Those engines receive the base values and the mode fields, together with a one-cycle load strobe when the high byte of a base value is written. The engines and the arbiter are outside this block.

Top module: `dmac_host_regs`

## Requirements
- R1: After `rst`, every channel mask is 1, the byte pointer is on the low byte, and the following are all zero: the command byte, every mode field, the software requests, the terminal-count flags, the base offsets and the base counts.
- R2: For channel n (0..3), port 2n is the offset and port 2n+1 is the count. The first written byte goes to bits [7:0] and the second to bits [15:8]. In the cycle after a high-byte write, `off_load[n]` or `cnt_load[n]` is 1 for exactly one cycle. It is 0 after a low-byte write.
- R3: One byte pointer serves all ports 0x0 to 0x7 and toggles after each read or write of any of them. A write of any data to port 0xC returns the pointer to the low byte.
- R4: A read of port 2n returns the low byte or the high byte of `live_off` for channel n, as the pointer selects. A read of port 2n+1 does the same for `live_cnt`. Channel n occupies bits [16n+15:16n] of these inputs.
- R5: A write to port 0xA sets the mask of channel `wdata[1:0]` to `wdata[2]`. Bits [7:3] are ignored.
- R6: A write to port 0xF loads all four masks from `wdata[3:0]`, where bit n is channel n and 1 means masked. A write of any data to port 0xE clears all four masks.
- R7: A write to port 0xB updates the mode of channel `wdata[1:0]`. The transfer type is `wdata[3:2]` (00 verify, 01 to memory, 10 from memory). Auto-init is `wdata[4]` and decrement is `wdata[5]`. The transfer mode is `wdata[7:6]` (00 demand, 01 single, 10 block, 11 cascade). The other channels keep their modes.
- R8: A write to port 0x9 sets the software request of channel `wdata[1:0]` to `wdata[2]`. The request appears on `soft_req`.
- R9: A read of port 0x8 returns bit 4+n = `dreq_in[n]` OR the software request of channel n, and bit n = the terminal-count flag of channel n. A pulse on `tc_in[n]` sets the flag, and the flag stays set until a status read. The status read clears the flags, except that a pulse arriving in the same cycle as the read leaves its flag set.
- R10: A write to port 0x8 loads `cmd_word` with the written byte.
- R11: A write of any data to port 0xD returns all state to the R1 values, and `chan_reset` is 1 for the next cycle.
- R12: A read of ports 0x9 to 0xF returns 0 and changes neither the masks nor the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| dreq_in | input | 4 | Request lines from peripherals |
| tc_in | input | 4 | Terminal-count pulses from channel engines |
| live_off | input | 64 | Current offsets, 16 bits per channel |
| live_cnt | input | 64 | Current countdowns, 16 bits per channel |
| base_off | output | 64 | Programmed start offsets |
| base_cnt | output | 64 | Programmed block counts |
| off_load | output | 4 | Offset load strobe per channel |
| cnt_load | output | 4 | Count load strobe per channel |
| chan_mask | output | 4 | Channel masks (1 = disabled) |
| soft_req | output | 4 | Software requests |
| cmd_word | output | 8 | Command byte |
| mode_kind | output | 8 | Transfer mode, 2 bits per channel |
| mode_type | output | 8 | Transfer type, 2 bits per channel |
| mode_autoinit | output | 4 | Auto-init per channel |
| mode_decr | output | 4 | Address decrement per channel |
| chan_reset | output | 1 | One-cycle reset pulse to channel engines |

## Verification
Offsets and counts are written with a distinct 16-bit value per channel, so bytes landing in the wrong channel or the wrong half are told apart. A cross-port sequence leaves a low byte on one channel and then writes another channel's port, which separates one shared byte pointer from per-register pointers. A clear issued in the middle of a word separates a working clear from a missing one. All 256 mode bytes, all 16 master-mask values and all 256 command bytes are swept. The request-line sweep separates the pending nibble from the terminal-count nibble. A terminal-count pulse that coincides with a status read shows whether a new event is lost. Reads of the strobe ports, followed by a byte write, show that a read of those ports leaves the pointer untouched.

// File: rtl/dmac_hif_pkg.sv
`timescale 1ns/1ps
package dmac_hif_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] P_STAT_CMD = 4'h8;
    localparam logic [ADDR_W-1:0] P_SWREQ    = 4'h9;
    localparam logic [ADDR_W-1:0] P_SMASK    = 4'hA;
    localparam logic [ADDR_W-1:0] P_MODE     = 4'hB;
    localparam logic [ADDR_W-1:0] P_FFCLR    = 4'hC;
    localparam logic [ADDR_W-1:0] P_MRST     = 4'hD;
    localparam logic [ADDR_W-1:0] P_ENALL    = 4'hE;
    localparam logic [ADDR_W-1:0] P_MMASK    = 4'hF;

    typedef enum logic [1:0] {XM_DEMAND, XM_SINGLE, XM_BLOCK, XM_CASCADE} xfer_kind_e;
    typedef enum logic [1:0] {XT_VERIFY, XT_TO_MEM, XT_FROM_MEM, XT_RSVD} xfer_type_e;

    // Field order matches the written mode byte bits [7:2]
    typedef struct packed {
        xfer_kind_e kind;
        logic       decr;
        logic       autoinit;
        xfer_type_e ttype;
    } chan_mode_t;

    typedef struct packed {
        logic            word_acc;
        logic            word_wr;
        logic [CH_W-1:0] ch;
        logic            is_cnt;
        logic            cmd_wr;
        logic            stat_rd;
        logic            req_wr;
        logic            smask_wr;
        logic            mode_wr;
        logic            ffclr;
        logic            mrst;
        logic            enall;
        logic            mmask_wr;
    } hif_stb_t;

    function automatic hif_stb_t decode_port(input logic [ADDR_W-1:0] a,
                                             input logic wr, input logic rd);
        hif_stb_t s;
        s.word_acc = (wr | rd) & ~a[ADDR_W-1];
        s.word_wr  = wr & ~a[ADDR_W-1];
        s.ch       = a[CH_W:1];
        s.is_cnt   = a[0];
        s.cmd_wr   = wr & (a == P_STAT_CMD);
        s.stat_rd  = rd & ~wr & (a == P_STAT_CMD);
        s.req_wr   = wr & (a == P_SWREQ);
        s.smask_wr = wr & (a == P_SMASK);
        s.mode_wr  = wr & (a == P_MODE);
        s.ffclr    = wr & (a == P_FFCLR);
        s.mrst     = wr & (a == P_MRST);
        s.enall    = wr & (a == P_ENALL);
        s.mmask_wr = wr & (a == P_MMASK);
        return s;
    endfunction
endpackage

// File: rtl/dmac_hif_wordregs.sv
`timescale 1ns/1ps
module dmac_hif_wordregs
    import dmac_hif_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int W   = WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  hif_stb_t            stb,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [NCH*W-1:0]    live_off,
    input  logic [NCH*W-1:0]    live_cnt,
    output logic [NCH*W-1:0]    base_off,
    output logic [NCH*W-1:0]    base_cnt,
    output logic [NCH-1:0]      off_ld,
    output logic [NCH-1:0]      cnt_ld,
    output logic [BYTE_W-1:0]   rd_byte
);
    localparam int HB = W - BYTE_W;

    logic ptr_hi;
    logic clr_all;
    assign clr_all = rst | stb.mrst;

    always_ff @(posedge clk) begin
        if (clr_all || stb.ffclr) ptr_hi <= 1'b0;
        else if (stb.word_acc)    ptr_hi <= ~ptr_hi;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [W-1:0] off_q, cnt_q;
        logic         off_ld_q, cnt_ld_q;
        logic         hit;
        assign hit = stb.word_wr && (int'(stb.ch) == c);

        always_ff @(posedge clk) begin
            if (clr_all) begin
                off_q <= '0; cnt_q <= '0; off_ld_q <= 1'b0; cnt_ld_q <= 1'b0;
            end else begin
                off_ld_q <= 1'b0;
                cnt_ld_q <= 1'b0;
                if (hit && !stb.is_cnt) begin
                    if (ptr_hi) begin off_q[W-1:HB] <= wdata; off_ld_q <= 1'b1; end
                    else        off_q[BYTE_W-1:0] <= wdata;
                end
                if (hit && stb.is_cnt) begin
                    if (ptr_hi) begin cnt_q[W-1:HB] <= wdata; cnt_ld_q <= 1'b1; end
                    else        cnt_q[BYTE_W-1:0] <= wdata;
                end
            end
        end
        assign base_off[c*W +: W] = off_q;
        assign base_cnt[c*W +: W] = cnt_q;
        assign off_ld[c] = off_ld_q;
        assign cnt_ld[c] = cnt_ld_q;
    end

    logic [W-1:0] rsel;
    always_comb begin
        rsel    = stb.is_cnt ? live_cnt[stb.ch*W +: W] : live_off[stb.ch*W +: W];
        rd_byte = ptr_hi ? rsel[W-1:HB] : rsel[BYTE_W-1:0];
    end

    logic unused_stb;
    assign unused_stb = ^{stb.cmd_wr, stb.stat_rd, stb.req_wr, stb.smask_wr,
                          stb.mode_wr, stb.enall, stb.mmask_wr};

    // R3: every access of a word port flips the pointer
    a_r3_ptr_toggle: assert property (@(posedge clk) disable iff (rst)
        stb.word_acc |=> (ptr_hi != $past(ptr_hi)));
    // R3: clear port forces low byte
    a_r3_ffclr_low: assert property (@(posedge clk) disable iff (rst)
        stb.ffclr |=> !ptr_hi);
    // R2: at most one load strobe per cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({off_ld, cnt_ld}));
    // R2: an offset strobe follows a high-byte offset write
    a_r2_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        (|off_ld) |-> $past(stb.word_wr && ptr_hi && !stb.is_cnt));
endmodule

// File: rtl/dmac_hif_ctrlregs.sv
`timescale 1ns/1ps
module dmac_hif_ctrlregs
    import dmac_hif_pkg::*;
#(
    parameter int NCH = NUM_CH,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  hif_stb_t          stb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NCH-1:0]    hw_req,
    input  logic [NCH-1:0]    tc_evt,
    output logic [BYTE_W-1:0] cmd_q,
    output chan_mode_t        modes [NCH],
    output logic [NCH-1:0]    mask,
    output logic [NCH-1:0]    swreq,
    output logic [BYTE_W-1:0] status
);
    logic [NCH-1:0] tc_q;

    always_ff @(posedge clk) begin
        if (rst || stb.mrst) begin
            cmd_q <= '0;
            mask  <= '1;
            swreq <= '0;
            tc_q  <= '0;
            for (int i = 0; i < NCH; i++) modes[i] <= '0;
        end else begin
            if (stb.cmd_wr)   cmd_q <= wdata;
            if (stb.smask_wr) mask[wdata[CW-1:0]] <= wdata[2];
            if (stb.mmask_wr) mask <= wdata[NCH-1:0];
            if (stb.enall)    mask <= '0;
            if (stb.req_wr)   swreq[wdata[CW-1:0]] <= wdata[2];
            if (stb.mode_wr)  modes[wdata[CW-1:0]] <= chan_mode_t'(wdata[BYTE_W-1:2]);
            tc_q <= (stb.stat_rd ? '0 : tc_q) | tc_evt;
        end
    end

    assign status = {hw_req | swreq, tc_q};

    logic unused_stb;
    assign unused_stb = ^{stb.word_acc, stb.word_wr, stb.ch, stb.is_cnt, stb.ffclr};

    // R11: master reset restores masks, command and requests
    a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
        stb.mrst |=> (mask == '1 && cmd_q == '0 && swreq == '0 && tc_q == '0));
    // R6: enable-all clears every mask
    a_r6_enable_all: assert property (@(posedge clk) disable iff (rst)
        stb.enall |=> (mask == '0));
    // R5: single-mask write lands on the addressed channel
    a_r5_single_mask: assert property (@(posedge clk) disable iff (rst)
        stb.smask_wr |=> (mask[$past(wdata[CW-1:0])] == $past(wdata[2])));
    // R9: flags are sticky without a status read
    a_r9_tc_hold: assert property (@(posedge clk) disable iff (rst)
        (!stb.stat_rd && !stb.mrst) |=> ((tc_q & $past(tc_q)) == $past(tc_q)));
    // R9: status read leaves only coincident events
    a_r9_tc_clear: assert property (@(posedge clk) disable iff (rst)
        (stb.stat_rd && !stb.mrst) |=> (tc_q == $past(tc_evt)));
endmodule

// File: rtl/dmac_host_regs.sv
`timescale 1ns/1ps
module dmac_host_regs
    import dmac_hif_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic                     io_wr,
    input  logic                     io_rd,
    input  logic [BYTE_W-1:0]        io_wdata,
    output logic [BYTE_W-1:0]        io_rdata,
    input  logic [NUM_CH-1:0]        dreq_in,
    input  logic [NUM_CH-1:0]        tc_in,
    input  logic [NUM_CH*WORD_W-1:0] live_off,
    input  logic [NUM_CH*WORD_W-1:0] live_cnt,
    output logic [NUM_CH*WORD_W-1:0] base_off,
    output logic [NUM_CH*WORD_W-1:0] base_cnt,
    output logic [NUM_CH-1:0]        off_load,
    output logic [NUM_CH-1:0]        cnt_load,
    output logic [NUM_CH-1:0]        chan_mask,
    output logic [NUM_CH-1:0]        soft_req,
    output logic [BYTE_W-1:0]        cmd_word,
    output logic [2*NUM_CH-1:0]      mode_kind,
    output logic [2*NUM_CH-1:0]      mode_type,
    output logic [NUM_CH-1:0]        mode_autoinit,
    output logic [NUM_CH-1:0]        mode_decr,
    output logic                     chan_reset
);
    hif_stb_t          stb;
    logic [BYTE_W-1:0] word_byte, status;
    chan_mode_t        modes [NUM_CH];

    assign stb = decode_port(io_addr, io_wr, io_rd);

    dmac_hif_wordregs #(.NCH(NUM_CH), .W(WORD_W)) u_words (
        .clk(clk), .rst(rst), .stb(stb), .wdata(io_wdata),
        .live_off(live_off), .live_cnt(live_cnt),
        .base_off(base_off), .base_cnt(base_cnt),
        .off_ld(off_load), .cnt_ld(cnt_load), .rd_byte(word_byte)
    );

    dmac_hif_ctrlregs #(.NCH(NUM_CH)) u_ctrl (
        .clk(clk), .rst(rst), .stb(stb), .wdata(io_wdata),
        .hw_req(dreq_in), .tc_evt(tc_in), .cmd_q(cmd_word), .modes(modes),
        .mask(chan_mask), .swreq(soft_req), .status(status)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
        assign mode_kind[2*c +: 2] = modes[c].kind;
        assign mode_type[2*c +: 2] = modes[c].ttype;
        assign mode_autoinit[c]    = modes[c].autoinit;
        assign mode_decr[c]        = modes[c].decr;
    end

    always_ff @(posedge clk) begin
        if (rst) chan_reset <= 1'b0;
        else     chan_reset <= stb.mrst;
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (!io_addr[ADDR_W-1])        io_rdata = word_byte;
            else if (io_addr == P_STAT_CMD) io_rdata = status;
        end
    end

    // R11: the channel reset pulse lasts one cycle after a single reset write
    a_r11_pulse_once: assert property (@(posedge clk) disable iff (rst)
        (chan_reset && !stb.mrst) |=> !chan_reset);
    // R12: strobe-port reads return zero
    a_r12_read_zero: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr[ADDR_W-1] && io_addr != P_STAT_CMD) |-> (io_rdata == '0));
endmodule

// File: tb/dmac_host_regs_tb.sv
`timescale 1ns/1ps
module dmac_host_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  dreq_in = '0, tc_in = '0;
    logic [63:0] live_off, live_cnt, base_off, base_cnt;
    logic [3:0]  off_load, cnt_load, chan_mask, soft_req;
    logic [7:0]  cmd_word, mode_kind, mode_type;
    logic [3:0]  mode_autoinit, mode_decr;
    logic        chan_reset;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dmac_host_regs dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dreq_in(dreq_in), .tc_in(tc_in),
        .live_off(live_off), .live_cnt(live_cnt), .base_off(base_off), .base_cnt(base_cnt),
        .off_load(off_load), .cnt_load(cnt_load), .chan_mask(chan_mask), .soft_req(soft_req),
        .cmd_word(cmd_word), .mode_kind(mode_kind), .mode_type(mode_type),
        .mode_autoinit(mode_autoinit), .mode_decr(mode_decr), .chan_reset(chan_reset)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    function automatic logic [15:0] off_pat(input int c);
        return 16'h1357 * 16'(c + 1) + 16'(c);
    endfunction
    function automatic logic [15:0] cnt_pat(input int c);
        return 16'hFFFF - 16'h0421 * 16'(c);
    endfunction

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [5:0]  em [4];
        logic [15:0] v;
        for (int c = 0; c < 4; c++) begin
            live_off[16*c +: 16] = 16'hA011 + 16'h0F0F * 16'(c);
            live_cnt[16*c +: 16] = 16'h5C20 + 16'h1102 * 16'(c);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 mask", 64'(chan_mask), 64'hF);
        chk("R1 cmd", 64'(cmd_word), 64'h0);
        chk("R1 modes", {40'h0, mode_kind, mode_type, mode_autoinit, mode_decr}, 64'h0);
        chk("R1 base", base_off | base_cnt, 64'h0);
        chk("R1 softreq", 64'(soft_req), 64'h0);
        rd(4'h8, d);
        chk("R1 status", 64'(d), 64'h0);

        // R2 offsets and counts per channel with load strobes
        for (int c = 0; c < 4; c++) begin
            wr(4'hC, 8'h5A);
            wr(4'(2*c), off_pat(c)[7:0]);
            chk("R2 no strobe after low byte", 64'(off_load | cnt_load), 64'h0);
            wr(4'(2*c), off_pat(c)[15:8]);
            chk("R2 offset strobe", 64'(off_load), 64'(4'b1 << c));
            chk("R2 offset value", 64'(base_off[16*c +: 16]), 64'(off_pat(c)));
            @(negedge clk);
            chk("R2 strobe one cycle", 64'(off_load), 64'h0);
            wr(4'(2*c+1), cnt_pat(c)[7:0]);
            wr(4'(2*c+1), cnt_pat(c)[15:8]);
            chk("R2 count strobe", 64'(cnt_load), 64'(4'b1 << c));
            chk("R2 count value", 64'(base_cnt[16*c +: 16]), 64'(cnt_pat(c)));
        end

        // R3 shared pointer across channels
        wr(4'hC, 8'hFF);
        wr(4'h0, 8'hAA);
        wr(4'h3, 8'hBB);
        chk("R3 shared pointer strobe", 64'(cnt_load), 64'h2);
        chk("R3 shared pointer value", 64'(base_cnt[31:16]), 64'({8'hBB, cnt_pat(1)[7:0]}));
        chk("R3 low byte on ch0", 64'(base_off[15:0]), 64'({off_pat(0)[15:8], 8'hAA}));
        // R3 clear in the middle of a word
        wr(4'h4, 8'h11);
        wr(4'hC, 8'h00);
        wr(4'h4, 8'h22);
        chk("R3 clear returns to low", 64'(off_load), 64'h0);
        wr(4'h4, 8'h33);
        chk("R3 after clear value", 64'(base_off[47:32]), 64'h3322);

        // R4 live readback, low then high
        for (int c = 0; c < 4; c++) begin
            wr(4'hC, 8'h01);
            rd(4'(2*c), d);   chk("R4 offset low", 64'(d), 64'(live_off[16*c +: 8]));
            rd(4'(2*c), d);   chk("R4 offset high", 64'(d), 64'(live_off[16*c+8 +: 8]));
            rd(4'(2*c+1), d); chk("R4 count low", 64'(d), 64'(live_cnt[16*c +: 8]));
            rd(4'(2*c+1), d); chk("R4 count high", 64'(d), 64'(live_cnt[16*c+8 +: 8]));
        end
        wr(4'hC, 8'h01);
        rd(4'h0, d);
        rd(4'h7, d);
        chk("R3 read advances shared pointer", 64'(d), 64'(live_cnt[63:56]));

        // R5 single mask
        v = 16'hF;
        for (int c = 0; c < 4; c++) begin
            wr(4'hA, 8'hF0 | 8'(c));
            v[c] = 1'b0;
            chk("R5 clear mask", 64'(chan_mask), 64'(v[3:0]));
        end
        for (int c = 0; c < 4; c++) begin
            wr(4'hA, 8'h04 | 8'(c));
            v[c] = 1'b1;
            chk("R5 set mask", 64'(chan_mask), 64'(v[3:0]));
        end

        // R6 master mask sweep and enable-all
        for (int m = 0; m < 16; m++) begin
            wr(4'hF, 8'hA0 | 8'(m));
            chk("R6 master mask", 64'(chan_mask), 64'(m));
        end
        wr(4'hE, 8'h9C);
        chk("R6 enable all", 64'(chan_mask), 64'h0);

        // R7 mode sweep over every byte
        for (int c = 0; c < 4; c++) em[c] = '0;
        for (int m = 0; m < 256; m++) begin
            logic [7:0] mb;
            logic [7:0] ek, et;
            logic [3:0] ea, ed;
            mb = 8'(m);
            wr(4'hB, mb);
            em[mb[1:0]] = mb[7:2];
            for (int c = 0; c < 4; c++) begin
                ek[2*c +: 2] = em[c][5:4];
                ed[c]        = em[c][3];
                ea[c]        = em[c][2];
                et[2*c +: 2] = em[c][1:0];
            end
            chk("R7 mode fields", {40'h0, mode_kind, mode_type, mode_autoinit, mode_decr},
                {40'h0, ek, et, ea, ed});
        end

        // R8 software requests, R9 status pending nibble
        for (int c = 0; c < 4; c++) begin
            wr(4'h9, 8'h04 | 8'(c));
            chk("R8 request set", 64'(soft_req), 64'(4'b1 << c));
            rd(4'h8, d);
            chk("R9 status shows soft request", 64'(d), 64'({4'b1 << c, 4'h0}));
            wr(4'h9, 8'(c));
            chk("R8 request clear", 64'(soft_req), 64'h0);
        end
        for (int m = 0; m < 16; m++) begin
            dreq_in = 4'(m);
            rd(4'h8, d);
            chk("R9 pending nibble", 64'(d), 64'({4'(m), 4'h0}));
        end
        dreq_in = '0;

        // R9 terminal count flags
        @(negedge clk); tc_in = 4'b0101;
        @(negedge clk); tc_in = 4'b0000;
        rd(4'h8, d);
        chk("R9 tc flags set", 64'(d), 64'h05);
        rd(4'h8, d);
        chk("R9 tc cleared by read", 64'(d), 64'h00);
        @(negedge clk); tc_in = 4'b0010;
        @(negedge clk); tc_in = 4'b0000;
        @(negedge clk);
        io_addr = 4'h8; io_rd = 1'b1; tc_in = 4'b1000;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0; tc_in = 4'b0000;
        chk("R9 read before coincident pulse", 64'(d), 64'h02);
        rd(4'h8, d);
        chk("R9 coincident pulse kept", 64'(d), 64'h08);

        // R10 command sweep
        for (int m = 0; m < 256; m++) begin
            wr(4'h8, 8'(m));
            chk("R10 command", 64'(cmd_word), 64'(m));
        end

        // R12 reads of strobe ports
        wr(4'hF, 8'h06);
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h44);
        for (int a = 9; a < 16; a++) begin
            rd(4'(a), d);
            chk("R12 read zero", 64'(d), 64'h0);
        end
        chk("R12 mask untouched", 64'(chan_mask), 64'h6);
        wr(4'h2, 8'h55);
        chk("R12 pointer untouched", 64'(off_load), 64'h2);
        chk("R12 value", 64'(base_off[31:16]), 64'h5544);

        // R11 master reset
        wr(4'h9, 8'h07);
        @(negedge clk); tc_in = 4'b1111;
        @(negedge clk); tc_in = 4'b0000;
        wr(4'h0, 8'h12);
        wr(4'hD, 8'h77);
        chk("R11 chan_reset pulse", 64'(chan_reset), 64'h1);
        chk("R11 mask", 64'(chan_mask), 64'hF);
        chk("R11 cmd and modes", {32'h0, cmd_word, mode_kind, mode_type, mode_autoinit, mode_decr},
            64'h0);
        chk("R11 base cleared", base_off | base_cnt, 64'h0);
        chk("R11 soft request", 64'(soft_req), 64'h0);
        @(negedge clk);
        chk("R11 pulse ends", 64'(chan_reset), 64'h0);
        rd(4'h8, d);
        chk("R11 status cleared", 64'(d), 64'h0);
        wr(4'h0, 8'h12);
        chk("R11 pointer low", 64'(off_load), 64'h0);
        chk("R11 low byte", 64'(base_off[15:0]), 64'h0012);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule